// File: doc/BRIEF.md
# DMA Channel Address and Count Register Bank

This block keeps the per-channel transfer address and transfer length of a four-channel DMA controller that is programmed through an 8-bit I/O port. Each channel has a base address and a base count, both 16 bits wide, written one byte at a time. It also has a current address and a running tally of transferred data, which the transfer engine advances. A single byte pointer, shared by all channels, decides whether the next port access touches the low or the high byte. Every access inside the channel window flips the pointer. The control decoder can force the pointer back to the low byte with a clear strobe or a master-clear strobe.

Writing the high byte of either base register restarts that channel. The current address is loaded from the base address and the tally is cleared. Reads do not return a stored register. They return a value computed live: the remaining count, or the current address moved forward or backward by the tally. The direction of that movement comes from a per-channel input. A per-channel step input advances the tally by one transfer unit, and a terminal-count output rises once the programmed length has been moved.

The parameter `CHAN_SHIFT` selects the controller width. With 0, the controller moves bytes, and port addresses map straight onto register indices. With 1, the controller moves 16-bit words, port addresses are word-spaced, and the current address and tally are held in bytes.

Top module: `dma_addr_count_bank`

## Requirements
- R1: After reset, every base, current and tally register is zero, the byte pointer selects the low byte, `tcOut` is 0 and all readbacks are 0.
- R2: The register index is `(ioAddr >> CHAN_SHIFT) & 0xF`. Indices 0 to 7 form the channel window. Within the window, index bit 0 selects address (0) or count (1) and index bits 2:1 give the channel number. With `CHAN_SHIFT`=1, `ioAddr` bit 0 has no effect.
- R3: Each read or write inside the window toggles the byte pointer, so on a freshly cleared pointer the first access reaches the low byte and the second the high byte.
- R4: `ptrClear` or `masterClear` makes the pointer select the low byte from the next cycle on. An access in the same cycle still uses the pointer value it found.
- R5: A write with the pointer low replaces bits 7:0 of the selected base register only. The current address, the tally and `tcOut` are left as they were.
- R6: A write with the pointer high replaces bits 15:8 of the selected base register and restarts the channel: the current address takes the (updated) base address and the tally becomes zero, whichever of the two registers was written.
- R7: Count readback is `(base count − units transferred) mod 2^16`.
- R8: Address readback is `(current address ± units transferred) mod 2^16`. The sign is minus while `chanDecr[c]` is 1 and plus while it is 0, and is applied live at read time.
- R9: A read returns bits 7:0 of the computed 16-bit value when the pointer is low and bits 15:8 when it is high.
- R10: While `tcOut[c]` is 0, a cycle with `xferStep[c]`=1 adds one transfer unit to channel c's tally.
- R11: `tcOut[c]` is 1 exactly when the tally is at least base count + 1 units. While it is 1, steps are ignored, so the count readback stays at 0xFFFF until a restart.
- R12: An access with index 8 to 15 reads as 0x00, changes no register and leaves the pointer as it was.
- R13: When a restart and a step for the same channel fall in the same cycle, the restart wins and the tally is zero afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ioAddr | input | ADDR_W | Port address of the current access |
| ioWrEn | input | 1 | Port write strobe, one cycle per byte |
| ioRdEn | input | 1 | Port read strobe, one cycle per byte |
| ioWrData | input | 8 | Write data byte |
| ioRdData | output | 8 | Read data byte, combinational from the current state |
| ptrClear | input | 1 | Clear the byte pointer |
| masterClear | input | 1 | Controller master clear; clears the byte pointer |
| chanDecr | input | 4 | Per-channel direction: 1 = address moves downward |
| xferStep | input | 4 | Per-channel one-unit transfer progress |
| tcOut | output | 4 | Per-channel terminal count reached |

## Verification
The bench builds two copies side by side from the same stimulus: one with `CHAN_SHIFT`=0 and one with `CHAN_SHIFT`=1. In the wide copy, `ioAddr` bit 0 is toggled on every access, which exercises the address aliasing and the byte-held current address and tally. A single word-based reference model serves both copies, because the readback must not depend on the width. The stimulus reaches the address wrap in both directions, the count running past zero into terminal count, restart and step in the same cycle, pointer clears coinciding with accesses, and accesses outside the channel window.

// File: rtl/dacb_pkg.sv
package dacb_pkg;
  localparam int CH_NUM = 4;
  localparam int CH_W   = $clog2(CH_NUM);
  localparam int BYTE_W = 8;
  localparam int REG_W  = 2 * BYTE_W;
  localparam int IDX_W  = 4;

  // Strobes from the port decoder to the register datapath
  typedef struct packed {
    logic            wrLow;     // byte write with pointer low
    logic            wrHigh;    // byte write with pointer high (restarts channel)
    logic            rdSel;     // read inside channel window
    logic            isCount;   // 1 = count register, 0 = address register
    logic [CH_W-1:0] chanSel;   // channel number
    logic            highByte;  // pointer state for read byte select
  } bankStrobe_t;
endpackage

// File: rtl/dacb_ctrl.sv
module dacb_ctrl
  import dacb_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int CHAN_SHIFT = 0
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [ADDR_W-1:0] ioAddr,
  input  logic        ioWrEn,
  input  logic        ioRdEn,
  input  logic        ptrClear,
  input  logic        masterClear,
  output bankStrobe_t strobe,
  output logic        ptrHigh
);
  logic [IDX_W-1:0] regIdx;
  logic inWindow;
  logic access;

  // Register index: port address scaled by controller width
  assign regIdx   = IDX_W'(ioAddr >> CHAN_SHIFT);
  assign inWindow = !regIdx[IDX_W-1];
  assign access   = inWindow && (ioWrEn || ioRdEn);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptrHigh <= 1'b0;
    end else if (ptrClear || masterClear) begin
      ptrHigh <= 1'b0;
    end else if (access) begin
      ptrHigh <= !ptrHigh;
    end
  end

  always_comb begin
    strobe.wrLow    = ioWrEn && inWindow && !ptrHigh;
    strobe.wrHigh   = ioWrEn && inWindow && ptrHigh;
    strobe.rdSel    = ioRdEn && inWindow;
    strobe.isCount  = regIdx[0];
    strobe.chanSel  = regIdx[CH_W:1];
    strobe.highByte = ptrHigh;
  end
endmodule

// File: rtl/dacb_datapath.sv
module dacb_datapath
  import dacb_pkg::*;
#(
  parameter int CHAN_SHIFT = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  bankStrobe_t       strobe,
  input  logic [BYTE_W-1:0] ioWrData,
  input  logic [CH_NUM-1:0] chanDecr,
  input  logic [CH_NUM-1:0] xferStep,
  output logic [BYTE_W-1:0] rdByte,
  output logic [CH_NUM-1:0] tcOut
);
  // Current address is held in bytes; tally in bytes with room for base+1 units
  localparam int CUR_W = REG_W + CHAN_SHIFT;
  localparam int XF_W  = REG_W + 1 + CHAN_SHIFT;
  localparam logic [XF_W-1:0] UNIT = XF_W'(1) << CHAN_SHIFT;

  logic [REG_W-1:0] addrView [CH_NUM];
  logic [REG_W-1:0] cntView  [CH_NUM];

  for (genvar ch = 0; ch < CH_NUM; ch++) begin : g_chan
    logic [REG_W-1:0] baseAddr;
    logic [REG_W-1:0] baseCnt;
    logic [CUR_W-1:0] curAddr;
    logic [XF_W-1:0]  xferBytes;
    logic [XF_W-1:0]  tcTarget;
    logic [XF_W-1:0]  addrSum;
    logic [XF_W-1:0]  cntDiff;
    logic [REG_W-1:0] reloadAddr;
    logic             hit;
    logic             tcHit;

    assign hit        = (strobe.chanSel == CH_W'(ch));
    assign reloadAddr = strobe.isCount ? baseAddr : {ioWrData, baseAddr[BYTE_W-1:0]};
    assign tcTarget   = XF_W'({1'b0, baseCnt} + (REG_W + 1)'(1)) << CHAN_SHIFT;
    assign tcHit      = (xferBytes >= tcTarget);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        baseAddr  <= '0;
        baseCnt   <= '0;
        curAddr   <= '0;
        xferBytes <= '0;
      end else begin
        if (hit && strobe.wrLow) begin
          if (strobe.isCount) baseCnt[BYTE_W-1:0]  <= ioWrData;
          else                baseAddr[BYTE_W-1:0] <= ioWrData;
        end
        if (hit && strobe.wrHigh) begin
          if (strobe.isCount) baseCnt[REG_W-1:BYTE_W]  <= ioWrData;
          else                baseAddr[REG_W-1:BYTE_W] <= ioWrData;
          curAddr   <= CUR_W'(reloadAddr) << CHAN_SHIFT;
          xferBytes <= '0;
        end else if (xferStep[ch] && !tcHit) begin
          xferBytes <= xferBytes + UNIT;
        end
      end
    end

    // Live readback from current state and direction
    assign addrSum = chanDecr[ch] ? (XF_W'(curAddr) - xferBytes)
                                  : (XF_W'(curAddr) + xferBytes);
    assign cntDiff = (XF_W'(baseCnt) << CHAN_SHIFT) - xferBytes;

    assign addrView[ch] = REG_W'(addrSum >> CHAN_SHIFT);
    assign cntView[ch]  = REG_W'(cntDiff >> CHAN_SHIFT);
    assign tcOut[ch]    = tcHit;
  end

  logic [REG_W-1:0] selView;

  always_comb begin
    selView = strobe.isCount ? cntView[strobe.chanSel] : addrView[strobe.chanSel];
    if (!strobe.rdSel)        rdByte = '0;
    else if (strobe.highByte) rdByte = selView[REG_W-1:BYTE_W];
    else                      rdByte = selView[BYTE_W-1:0];
  end
endmodule

// File: rtl/dma_addr_count_bank.sv
module dma_addr_count_bank
  import dacb_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int CHAN_SHIFT = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] ioAddr,
  input  logic              ioWrEn,
  input  logic              ioRdEn,
  input  logic [7:0]        ioWrData,
  output logic [7:0]        ioRdData,
  input  logic              ptrClear,
  input  logic              masterClear,
  input  logic [3:0]        chanDecr,
  input  logic [3:0]        xferStep,
  output logic [3:0]        tcOut
);
  bankStrobe_t bankStrobe;
  logic        ptrHigh;

  dacb_ctrl #(.ADDR_W(ADDR_W), .CHAN_SHIFT(CHAN_SHIFT)) u_ctrl (
    .clk(clk), .rstN(rstN), .ioAddr(ioAddr), .ioWrEn(ioWrEn), .ioRdEn(ioRdEn),
    .ptrClear(ptrClear), .masterClear(masterClear),
    .strobe(bankStrobe), .ptrHigh(ptrHigh)
  );

  dacb_datapath #(.CHAN_SHIFT(CHAN_SHIFT)) u_data (
    .clk(clk), .rstN(rstN), .strobe(bankStrobe), .ioWrData(ioWrData),
    .chanDecr(chanDecr), .xferStep(xferStep),
    .rdByte(ioRdData), .tcOut(tcOut)
  );
endmodule

// File: rtl/dacb_checker.sv
module dacb_checker #(
  parameter int ADDR_W     = 8,
  parameter int CHAN_SHIFT = 0
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] ioAddr,
  input logic              ioWrEn,
  input logic              ioRdEn,
  input logic [7:0]        ioRdData,
  input logic              ptrClear,
  input logic              masterClear,
  input logic [3:0]        tcOut,
  input logic              ptrHigh
);
  logic [3:0] idx;
  logic       inWin;
  logic       acc;
  logic [1:0] chanQ;

  assign idx   = 4'(ioAddr >> CHAN_SHIFT);
  assign inWin = !idx[3];
  assign acc   = inWin && (ioWrEn || ioRdEn);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chanQ <= '0;
    else       chanQ <= idx[2:1];
  end

  assert_ptr_clear_R4: assert property (@(posedge clk) disable iff (!rstN)
    (ptrClear || masterClear) |=> !ptrHigh);

  assert_ptr_toggle_R3: assert property (@(posedge clk) disable iff (!rstN)
    (acc && !ptrClear && !masterClear) |=> (ptrHigh != $past(ptrHigh)));

  assert_ptr_hold_R12: assert property (@(posedge clk) disable iff (!rstN)
    (!acc && !ptrClear && !masterClear) |=> $stable(ptrHigh));

  assert_out_window_zero_R12: assert property (@(posedge clk) disable iff (!rstN)
    (ioRdEn && !inWin) |-> (ioRdData == 8'h00));

  assert_restart_clears_tc_R6: assert property (@(posedge clk) disable iff (!rstN)
    (ioWrEn && inWin && ptrHigh) |=> !tcOut[chanQ]);

  assert_tc_no_fall_R11: assert property (@(posedge clk) disable iff (!rstN)
    !ioWrEn |=> ((tcOut | ~$past(tcOut)) == 4'hF));
endmodule

bind dma_addr_count_bank dacb_checker #(.ADDR_W(ADDR_W), .CHAN_SHIFT(CHAN_SHIFT)) u_chk (
  .clk(clk), .rstN(rstN), .ioAddr(ioAddr), .ioWrEn(ioWrEn), .ioRdEn(ioRdEn),
  .ioRdData(ioRdData), .ptrClear(ptrClear), .masterClear(masterClear),
  .tcOut(tcOut), .ptrHigh(ptrHigh)
);

// File: tb/dma_addr_count_bank_bench.sv
`timescale 1ns/1ps
module dma_addr_count_bank_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] addrNarrow = '0;
  logic [7:0] addrWide = '0;
  logic       wrEn = 1'b0;
  logic       rdEn = 1'b0;
  logic [7:0] wrData = '0;
  logic       pClr = 1'b0;
  logic       mClr = 1'b0;
  logic [3:0] decr = '0;
  logic [3:0] steps = '0;
  logic [7:0] rdNarrow, rdWide;
  logic [3:0] tcNarrow, tcWide;

  always #10 clk = ~clk;  // 50 MHz

  dma_addr_count_bank #(.ADDR_W(8), .CHAN_SHIFT(0)) u_dma_addr_count_bank (
    .clk(clk), .rstN(rstN), .ioAddr(addrNarrow), .ioWrEn(wrEn), .ioRdEn(rdEn),
    .ioWrData(wrData), .ioRdData(rdNarrow), .ptrClear(pClr), .masterClear(mClr),
    .chanDecr(decr), .xferStep(steps), .tcOut(tcNarrow));

  dma_addr_count_bank #(.ADDR_W(8), .CHAN_SHIFT(1)) u_dma_addr_count_bank_wide (
    .clk(clk), .rstN(rstN), .ioAddr(addrWide), .ioWrEn(wrEn), .ioRdEn(rdEn),
    .ioWrData(wrData), .ioRdData(rdWide), .ptrClear(pClr), .masterClear(mClr),
    .chanDecr(decr), .xferStep(steps), .tcOut(tcWide));

  int nChecks = 0;
  int nFail = 0;
  bit oddBit = 1'b0;

  // Reference model in transfer units (width independent)
  int mBaseA [4];
  int mBaseC [4];
  int mCurA  [4];
  int mXf    [4];
  bit mPtr;

  function automatic bit mTc(int c);
    return mXf[c] >= mBaseC[c] + 1;
  endfunction

  function automatic int mRead(int idx);
    int c, v;
    if (idx >= 8) return 0;
    c = (idx >> 1) & 3;
    if (idx & 1) v = (mBaseC[c] - mXf[c]) & 'hFFFF;
    else         v = (mCurA[c] + (decr[c] ? -mXf[c] : mXf[c])) & 'hFFFF;
    return mPtr ? ((v >> 8) & 'hFF) : (v & 'hFF);
  endfunction

  task automatic chk(string tag, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
  endtask

  // One clock: drive at negedge, compare before the edge, advance model at edge
  task automatic doCycle(string tag, bit wr, bit rd, int idx, int data,
                         bit pc, bit mc, logic [3:0] st);
    bit tcPre [4];
    bit inWin, acc, p;
    int c;
    int expTc;
    @(negedge clk);
    wrEn = wr; rdEn = rd; wrData = 8'(data); pClr = pc; mClr = mc; steps = st;
    addrNarrow = 8'(idx);
    addrWide = 8'((idx << 1) | int'(oddBit));
    oddBit = !oddBit;
    #2;
    expTc = 0;
    for (int k = 0; k < 4; k++) begin
      tcPre[k] = mTc(k);
      expTc |= int'(tcPre[k]) << k;
    end
    chk({tag, " tc narrow"}, int'(tcNarrow), expTc);
    chk({tag, " tc wide"}, int'(tcWide), expTc);
    if (rd) begin
      chk({tag, " rd narrow"}, int'(rdNarrow), mRead(idx));
      chk({tag, " rd wide"}, int'(rdWide), mRead(idx));
    end
    @(posedge clk);
    inWin = (idx < 8);
    acc = inWin && (wr || rd);
    p = mPtr;
    c = (idx >> 1) & 3;
    for (int k = 0; k < 4; k++)
      if (st[k] && !tcPre[k] && !(wr && inWin && p && k == c)) mXf[k]++;
    if (wr && inWin) begin
      if (!p) begin
        if (idx & 1) mBaseC[c] = (mBaseC[c] & 'hFF00) | (data & 'hFF);
        else         mBaseA[c] = (mBaseA[c] & 'hFF00) | (data & 'hFF);
      end else begin
        if (idx & 1) mBaseC[c] = (mBaseC[c] & 'hFF) | ((data & 'hFF) << 8);
        else         mBaseA[c] = (mBaseA[c] & 'hFF) | ((data & 'hFF) << 8);
        mCurA[c] = mBaseA[c];
        mXf[c] = 0;
      end
    end
    if (pc || mc) mPtr = 0;
    else if (acc) mPtr = !mPtr;
  endtask

  task automatic wr(string tag, int idx, int data);
    doCycle(tag, 1, 0, idx, data, 0, 0, 4'h0);
  endtask
  task automatic rd(string tag, int idx);
    doCycle(tag, 0, 1, idx, 0, 0, 0, 4'h0);
  endtask
  task automatic step(string tag, logic [3:0] st);
    doCycle(tag, 0, 0, 0, 0, 0, 0, st);
  endtask
  task automatic prog(string tag, int idx, int val);
    wr(tag, idx, val & 'hFF);
    wr(tag, idx, (val >> 8) & 'hFF);
  endtask
  task automatic rd16(string tag, int idx);
    rd(tag, idx);
    rd(tag, idx);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    for (int k = 0; k < 4; k++) begin
      mBaseA[k] = 0; mBaseC[k] = 0; mCurA[k] = 0; mXf[k] = 0;
    end
    mPtr = 0;
    repeat (3) @(posedge clk);
    #3;
    chk("R1 reset tc narrow", int'(tcNarrow), 0);
    chk("R1 reset tc wide", int'(tcWide), 0);
    rstN = 1'b1;
    rd16("R1 reset addr ch0", 0);
    rd16("R1 reset count ch3", 7);

    // R2 R6 R7 R8 R9: program channel 1
    prog("R6 ch1 addr", 2, 'h1234);
    prog("R6 ch1 count", 3, 'h0003);
    rd16("R8 R9 ch1 addr", 2);
    rd16("R7 R9 ch1 count", 3);

    // R10: progress
    step("R10 step ch1", 4'b0010);
    step("R10 step ch1", 4'b0010);
    rd16("R10 R8 ch1 addr after 2", 2);
    rd16("R10 R7 ch1 count after 2", 3);

    // R8 live direction change
    decr[1] = 1'b1;
    rd16("R8 ch1 addr decr live", 2);
    decr[1] = 1'b0;

    // R11: run into terminal count, extra step ignored
    step("R11 step ch1", 4'b0010);
    step("R11 step ch1", 4'b0010);
    step("R11 extra step ch1", 4'b0010);
    rd16("R11 ch1 count at tc", 3);
    rd16("R11 ch1 addr at tc", 2);

    // R5 low-byte write only, then R4 pointer clear
    wr("R5 low write ch1 addr", 2, 'h99);
    doCycle("R4 ptr clear", 0, 0, 0, 0, 1, 0, 4'h0);
    rd16("R5 ch1 addr kept", 2);
    rd16("R5 ch1 count kept", 3);

    // R8 wrap downward on ch2
    decr[2] = 1'b1;
    prog("R6 ch2 addr", 4, 'h0001);
    prog("R6 ch2 count", 5, 'h0010);
    step("R10 ch2", 4'b0100);
    step("R10 ch2", 4'b0100);
    step("R10 ch2", 4'b0100);
    rd16("R8 ch2 addr wrap down", 4);
    rd16("R7 ch2 count", 5);

    // R8 wrap upward on ch0, simultaneous steps all channels
    prog("R6 ch0 addr", 0, 'hFFFF);
    prog("R6 ch0 count", 1, 'h0001);
    prog("R6 ch3 count", 7, 'h0000);
    step("R10 all", 4'b1111);
    rd16("R8 ch0 addr wrap up", 0);
    rd16("R7 ch3 count", 7);
    step("R11 all", 4'b1111);
    rd16("R11 ch0 count", 1);

    // R12 outside window
    rd("R12 rd idx8", 8);
    rd("R12 rd idx15", 15);
    doCycle("R12 wr idx12", 1, 0, 12, 'hAB, 0, 0, 4'h0);
    rd16("R12 ch0 addr after outside", 0);

    // R4 master clear after one access; clear coinciding with access
    rd("R4 single read", 2);
    doCycle("R4 master clear", 0, 0, 0, 0, 0, 1, 4'h0);
    rd16("R4 ch1 addr after mclear", 2);
    rd("R3 first", 3);
    doCycle("R4 read with clear", 0, 1, 3, 0, 1, 0, 4'h0);
    rd16("R4 ch1 count after clear", 3);

    // R13 restart and step together; R6 restart through count write reloads addr
    wr("R13 ch1 count lo", 3, 'h05);
    doCycle("R13 ch1 count hi with step", 1, 0, 3, 'h00, 0, 0, 4'b0010);
    rd16("R13 ch1 count", 3);
    rd16("R6 ch1 addr reloaded", 2);
    step("R10 ch1", 4'b0010);
    rd16("R10 ch1 addr", 2);

    step("idle", 4'h0);
    summary();
    $finish;
  end
endmodule